// File: doc/BRIEF.md
# Pipelined Signed Shift-Add Multiplier

This block multiplies two two's-complement operands and returns the exact product at full width. The operand widths are set independently. At elaboration the block finds the narrower operand and makes it the multiplier. The wider operand is the multiplicand. Each pipeline row takes a two-bit slice of the multiplier, starting at the least significant end. It forms that slice's multiple of the sign-extended multiplicand and adds it, shifted into place, to a running sum. The row handling the most significant slice treats that slice as a signed digit and subtracts its weighted upper bit. This correction makes the final sum exact for negative multipliers, and the most negative values of both operands need no special case.

The block has no handshake. A single clock enable advances every register together, and a low enable freezes the whole pipeline. A caller that needs back-pressure lowers the enable; data in flight is then neither lost nor duplicated. The result for an operand pair appears a fixed number of enabled edges after that pair was sampled. An active-low asynchronous reset clears every stage to zero. The narrower operand must be at least 5 bits wide.

Top module: `smul_pipe`

## Requirements
- R1: `prod` equals the signed product of `x_in` and `y_in` sampled LAT enabled rising edges earlier. LAT = ceil(min(WIDTH_X, WIDTH_Y)/2) + 2, which gives 6 for the default 8 x 12.
- R2: On a rising edge with `ce` low, no register changes and `prod` holds its value. Operand pairs accepted before and after a stall come out in order, each with its own product.
- R3: While `rst_n` is low, `prod` is zero. After reset it stays zero until LAT enabled edges have occurred.
- R4: If either operand is zero, the product is zero.
- R5: An operand equal to 1 gives the other operand sign-extended. An operand equal to -1 (all ones) gives the negation of the other operand.
- R6: When both operands are non-zero, the most significant bit of `prod` equals the XOR of the two operand sign bits.
- R7: The product is exact at the extremes. Most negative times most negative gives 2^(WIDTH_X+WIDTH_Y-2). Most negative times most positive is also exact.
- R8: When WIDTH_X is greater than WIDTH_Y, the operands are exchanged internally. The latency then follows the narrower WIDTH_Y (LAT = 5 for an 11 x 5 instance), and the product is still exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all stages |
| ce | input | 1 | Clock enable; when high, all stages advance one step |
| x_in | input | WIDTH_X | First signed operand |
| y_in | input | WIDTH_Y | Second signed operand |
| prod | output | WIDTH_X+WIDTH_Y | Full-precision signed product |

## Verification
Each result is due exactly LAT enabled rising edges after its operands are sampled. That is 6 edges for the 8 x 12 instance and 5 edges for the 11 x 5 instance. The bench keeps a shift-register model of each instance, one entry per stage. The model moves only on edges where it drove `ce` high, and it compares `prod` on the falling edge after every rising edge. A stalled edge therefore leaves the expected value unchanged, and a late or early result fails. The zero fill after reset, stall runs with changing inputs, and directed corners go through the same model alongside the random traffic.

// File: rtl/smul_pkg.sv
package smul_pkg;

  function automatic int narrow_w(input int wx, input int wy);
    return (wx <= wy) ? wx : wy;
  endfunction

  function automatic int wide_w(input int wx, input int wy);
    return (wx <= wy) ? wy : wx;
  endfunction

  // two multiplier bits retired per row
  function automatic int row_count(input int nw);
    return (nw + 1) / 2;
  endfunction

endpackage

// File: rtl/smul_order.sv
module smul_order #(
  parameter int WX = 8,
  parameter int WY = 12,
  parameter int NW = 8,
  parameter int WW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [WX-1:0] x_in,
  input  logic [WY-1:0] y_in,
  output logic [NW-1:0] n_q,
  output logic [WW-1:0] w_q
);
  logic [NW-1:0] n_d;
  logic [WW-1:0] w_d;

  // narrower operand becomes the multiplier
  if (WX <= WY) begin : g_keep
    assign n_d = x_in;
    assign w_d = y_in;
  end else begin : g_swap
    assign n_d = y_in;
    assign w_d = x_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0;
      w_q <= '0;
    end else if (ce) begin
      n_q <= n_d;
      w_q <= w_d;
    end
  end

  AST_ORDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(n_q) && $stable(w_q))); // R2
endmodule

// File: rtl/smul_row.sv
module smul_row #(
  parameter int NW  = 8,
  parameter int WW  = 12,
  parameter int PW  = 20,
  parameter int ROW = 0,
  parameter bit TOP = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [NW-1:0] n_in,
  input  logic [WW-1:0] w_in,
  input  logic [PW-1:0] acc_in,
  output logic [NW-1:0] n_out,
  output logic [WW-1:0] w_out,
  output logic [PW-1:0] acc_out
);
  localparam int SH = 2 * ROW;

  logic [1:0]    dig;
  logic [PW-1:0] w_ext;
  logic [PW-1:0] pp_lo;
  logic [PW-1:0] pp_hi;
  logic [PW-1:0] term;

  // slice bits past the multiplier's top repeat its sign bit
  for (genvar j = 0; j < 2; j++) begin : g_dig
    localparam int P = (SH + j < NW) ? SH + j : NW - 1;
    assign dig[j] = n_in[P];
  end

  assign w_ext = {{(PW-WW){w_in[WW-1]}}, w_in};
  assign pp_lo = dig[0] ? w_ext : '0;
  assign pp_hi = dig[1] ? (w_ext << 1) : '0;

  if (TOP) begin : g_signed_digit
    // upper bit of the top slice carries negative weight
    assign term = pp_lo - pp_hi;
  end else begin : g_plain_digit
    assign term = pp_lo + pp_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_out   <= '0;
      w_out   <= '0;
      acc_out <= '0;
    end else if (ce) begin
      n_out   <= n_in;
      w_out   <= w_in;
      acc_out <= acc_in + (term << SH);
    end
  end

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(acc_out) && $stable(n_out) && $stable(w_out))); // R2

  if (TOP) begin : g_top_checks
    AST_ZERO_FACTOR: assert property (@(posedge clk) disable iff (!rst_n)
      ((n_out == '0) || (w_out == '0)) |-> (acc_out == '0)); // R4
    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
      ((n_out != '0) && (w_out != '0)) |-> (acc_out[PW-1] == (n_out[NW-1] ^ w_out[WW-1]))); // R6
  end
endmodule

// File: rtl/smul_pipe.sv
module smul_pipe
  import smul_pkg::*;
#(
  parameter int WIDTH_X = 8,
  parameter int WIDTH_Y = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ce,
  input  logic [WIDTH_X-1:0]         x_in,
  input  logic [WIDTH_Y-1:0]         y_in,
  output logic [WIDTH_X+WIDTH_Y-1:0] prod
);
  localparam int NW   = narrow_w(WIDTH_X, WIDTH_Y);
  localparam int WW   = wide_w(WIDTH_X, WIDTH_Y);
  localparam int PW   = WIDTH_X + WIDTH_Y;
  localparam int ROWS = row_count(NW);
  localparam int LAT  = ROWS + 2;
  localparam int CW   = $clog2(LAT + 1);

  logic [NW-1:0] n_st   [ROWS+1];
  logic [WW-1:0] w_st   [ROWS+1];
  logic [PW-1:0] acc_st [ROWS+1];

  smul_order #(.WX(WIDTH_X), .WY(WIDTH_Y), .NW(NW), .WW(WW)) u_order (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .x_in  (x_in),
    .y_in  (y_in),
    .n_q   (n_st[0]),
    .w_q   (w_st[0])
  );

  assign acc_st[0] = '0;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    smul_row #(
      .NW(NW), .WW(WW), .PW(PW), .ROW(r), .TOP(r == ROWS - 1)
    ) u_row (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce      (ce),
      .n_in    (n_st[r]),
      .w_in    (w_st[r]),
      .acc_in  (acc_st[r]),
      .n_out   (n_st[r+1]),
      .w_out   (w_st[r+1]),
      .acc_out (acc_st[r+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod <= '0;
    else if (ce) prod <= acc_st[ROWS];
  end

  // enabled edges since reset, saturating at the latency
  logic [CW-1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (ce && (warm < CW'(LAT))) warm <= warm + 1'b1;
  end

  AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (warm < CW'(LAT)) |-> (prod == '0)); // R3
  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(prod)); // R2
  AST_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && ((n_st[ROWS] == '0) || (w_st[ROWS] == '0))) |=> (prod == '0)); // R4
endmodule

// File: tb/smul_pipe_bench.sv
`timescale 1ns/1ps
module smul_pipe_bench;
  localparam int LA = 6;  // 8 x 12: ceil(8/2)+2
  localparam int LB = 5;  // 11 x 5: ceil(5/2)+2

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0;
  logic [7:0]  xa = '0;
  logic [11:0] ya = '0;
  logic [10:0] xb = '0;
  logic [4:0]  yb = '0;
  logic [19:0] pa;
  logic [15:0] pb;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;

  logic [19:0] mA [LA];
  logic [15:0] mB [LB];
  bit          sv [LA];
  bit          ss [LA];

  always #4 clk = ~clk;

  smul_pipe #(.WIDTH_X(8), .WIDTH_Y(12)) u_smul_pipe (
    .clk(clk), .rst_n(rst_n), .ce(ce), .x_in(xa), .y_in(ya), .prod(pa));
  smul_pipe #(.WIDTH_X(11), .WIDTH_Y(5)) u_smul_pipe_swp (
    .clk(clk), .rst_n(rst_n), .ce(ce), .x_in(xb), .y_in(yb), .prod(pb));

  function automatic logic [19:0] ref_a(input logic [7:0] x, input logic [11:0] y);
    logic signed [19:0] r;
    r = $signed(x) * $signed(y);
    return r;
  endfunction

  function automatic logic [15:0] ref_b(input logic [10:0] x, input logic [4:0] y);
    logic signed [15:0] r;
    r = $signed(x) * $signed(y);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input bit en, input logic [7:0] x1, input logic [11:0] y1,
                      input logic [10:0] x2, input logic [4:0] y2, input string tag);
    ce = en; xa = x1; ya = y1; xb = x2; yb = y2;
    @(posedge clk);
    if (en) begin
      for (int i = LA - 1; i > 0; i--) begin
        mA[i] = mA[i-1]; sv[i] = sv[i-1]; ss[i] = ss[i-1];
      end
      mA[0] = ref_a(x1, y1);
      sv[0] = (x1 != 0) && (y1 != 0);
      ss[0] = x1[7] ^ y1[11];
      for (int i = LB - 1; i > 0; i--) mB[i] = mB[i-1];
      mB[0] = ref_b(x2, y2);
    end
    @(negedge clk);
    chk(pa == mA[LA-1], tag, 32'(pa), 32'(mA[LA-1]));
    chk(pb == mB[LB-1], {tag, " R8 swapped"}, 32'(pb), 32'(mB[LB-1]));
    if (sv[LA-1]) chk(pa[19] == ss[LA-1], "R6 sign", 32'(pa[19]), 32'(ss[LA-1]));
  endtask

  // operands for the swapped instance derived from the first pair
  task automatic stepd(input bit en, input logic [7:0] x1, input logic [11:0] y1, input string tag);
    step(en, x1, y1, {{3{x1[7]}}, x1}, y1[4:0], tag);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < LA; i++) begin mA[i] = '0; sv[i] = 1'b0; ss[i] = 1'b0; end
    for (int i = 0; i < LB; i++) mB[i] = '0;
    repeat (3) @(negedge clk);
    chk(pa == '0, "R3 reset", 32'(pa), 32'h0);
    chk(pb == '0, "R3 reset swapped", 32'(pb), 32'h0);
    rst_n = 1'b1;
    // fill: outputs stay zero until the pipeline is full
    for (int i = 0; i < LA; i++) stepd(1'b1, 8'd5, 12'd7, "R3 fill");
    // zero operands
    stepd(1'b1, 8'd0, 12'hABC, "R4 zero x");
    stepd(1'b1, 8'h93, 12'd0, "R4 zero y");
    // unit and minus-one operands
    stepd(1'b1, 8'd1, 12'hED4, "R5 one x");
    stepd(1'b1, 8'h9C, 12'd1, "R5 one y");
    stepd(1'b1, 8'hFF, 12'h801, "R5 minus one x");
    stepd(1'b1, 8'h80, 12'hFFF, "R5 minus one y");
    // extremes
    step(1'b1, 8'h80, 12'h800, 11'h400, 5'h10, "R7 min*min");
    step(1'b1, 8'h7F, 12'h800, 11'h3FF, 5'h10, "R7 max*min");
    step(1'b1, 8'h80, 12'h7FF, 11'h400, 5'h0F, "R7 min*max");
    // stall with changing inputs
    for (int i = 0; i < 5; i++)
      step(1'b0, 8'($urandom), 12'($urandom), 11'($urandom), 5'($urandom), "R2 stall");
    for (int i = 0; i < LA; i++) stepd(1'b1, 8'd0, 12'd0, "R1 flush");
    // random traffic with enable gaps and sprinkled corners
    for (int i = 0; i < 800; i++) begin
      bit en;
      logic [7:0] x1; logic [11:0] y1; logic [10:0] x2; logic [4:0] y2;
      en = ($urandom % 4) != 0;
      x1 = 8'($urandom); y1 = 12'($urandom); x2 = 11'($urandom); y2 = 5'($urandom);
      case ($urandom % 10)
        0: begin x1 = 8'h80; x2 = 11'h400; end
        1: begin y1 = 12'h800; y2 = 5'h10; end
        2: begin x1 = 8'hFF; y2 = 5'h1F; end
        default: ;
      endcase
      step(en, x1, y1, x2, y2, en ? "R1 random" : "R2 random stall");
    end
    for (int i = 0; i < LA; i++) stepd(1'b1, 8'd0, 12'd0, "R1 drain");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule